// File: doc/BRIEF.md
# Programmable Acquisition Window Generator

This block decides which lines and pixels of an incoming video frame reach a memory writer. It runs on the pixel clock. It watches a frame-enable input for the edge chosen by a polarity bit, counts line-valid pulses from that edge, and skips a programmed number of lines. It then opens a programmed number of lines for acquisition. Inside each open line, a pixel-write strobe covers a horizontal span given by an offset and an active count. The active count is always rounded up to a whole group of 8 pixels.

When the last open line ends, the block emits a one-cycle frame-done pulse. The vertical counter then stays frozen until the next selected frame-enable edge. A selected edge that arrives in the middle of a frame restarts the counting.

A read-only status word returns the vertical configuration together with the synchronized levels of seven external trigger inputs.

Top module: `acq_window_gen`

## Requirements
- R1: Status word layout. Bits 21:0 echo the vertical configuration word. Bits 28:22 hold trig_i[0..6] after a two-flop synchronizer. The trigger order on trig_i, from index 0 to 6, is: 15-pin TTL trigger 0, 26-pin TTL trigger 1, 26-pin TTL trigger 0, opto trigger 0, opto trigger 1, differential trigger 0, differential trigger 1. Bits 31:29 read zero. A trigger change is visible in the status word after exactly two clock edges.
- R2: The vertical configuration word carries the line offset in bits 9:0 and the active line count in bits 21:10.
- R3: When fen_pol_i is 1, a rising edge of fen_i arms the vertical counter. When fen_pol_i is 0, a falling edge arms it. An edge of the other direction has no effect.
- R4: A line is counted when line-valid rises. The first offset lines after the arming edge are skipped. With an offset of 0, the first line after the edge is acquired.
- R5: Exactly the programmed number of lines following the offset assert line_act_o. No further line asserts it until the next arming edge.
- R6: With an active line count of 0, no line is acquired. frame_done_o still pulses once the offset lines have been counted.
- R7: Pixels are indexed from 0 in the first cycle of line-valid. In an acquired line, pix_wr_o pulses once for each index from the horizontal offset up to, but not including, the offset plus the active count rounded up to a multiple of 8. The strobe follows its pixel by one clock.
- R8: The write strobe is never issued for a pixel outside line-valid. A window that runs past the end of the line is cut off there.
- R9: frame_done_o is a single-cycle pulse, issued one clock after line-valid falls on the last acquired line.
- R10: An arming edge in the middle of a frame restarts both the skip count and the acquired-line count.
- R11: While reset is asserted, line_act_o, pix_wr_o, frame_done_o and the synchronized trigger bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fen_i | input | 1 | Frame-enable input |
| fen_pol_i | input | 1 | 1 selects the rising edge of fen_i, 0 selects the falling edge |
| lval_i | input | 1 | Line-valid input |
| vwin_cfg_i | input | 22 | Vertical configuration: offset in [9:0], active lines in [21:10] |
| hoff_i | input | 12 | Horizontal offset in pixels |
| hact_i | input | 12 | Horizontal active pixel count |
| trig_i | input | 7 | Trigger input levels, asynchronous |
| line_act_o | output | 1 | High while an acquired line is in progress |
| pix_wr_o | output | 1 | Pixel-write strobe |
| frame_done_o | output | 1 | One-cycle pulse at the end of the last acquired line |
| status_o | output | 32 | Read-only status word |

## Verification
Suppose the skip counter or the acquired-line counter drifts by one. The ports then show it on the very next frame as one line too many or too few carrying line_act_o. frame_done_o either appears a line early, appears a line late, or never appears at all.

Suppose the horizontal index or the rounding is wrong. Within the first acquired line, the number of pix_wr_o pulses per line differs from the rounded window clipped to the line length.

Suppose the edge detector loses its state. Frames armed with the wrong polarity then acquire lines, or a restart mid-frame fails to reset the counts. Both are visible within a single frame.

// File: rtl/acq_win_pkg.sv
package acq_win_pkg;
  localparam int VOFF_W = 10;
  localparam int VACT_W = 12;
  localparam int NTRIG  = 7;
  localparam int STAT_W = 32;
  localparam int VCFG_W = VOFF_W + VACT_W;
  localparam int PAD_W  = STAT_W - VCFG_W - NTRIG;

  typedef enum logic {
    V_IDLE = 1'b0,
    V_RUN  = 1'b1
  } vstate_e;
endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] meta_q;
  logic [N-1:0] hold_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        hold_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        hold_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_o = hold_q;
endmodule

// File: rtl/acq_vert_ctl.sv
module acq_vert_ctl
  import acq_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fe_edge,
  input  logic              lv_rise,
  input  logic              lv_level,
  input  logic [VOFF_W-1:0] voff,
  input  logic [VACT_W-1:0] vact,
  output logic              accept,
  output logic              line_act,
  output logic              frame_done
);
  vstate_e           st_q, st_n;
  logic [VOFF_W-1:0] skip_q, skip_n;
  logic [VACT_W-1:0] got_q, got_n;
  logic              line_q, line_n;
  logic              done_q, done_n;

  assign accept = (st_q == V_RUN) && (skip_q >= voff) && (got_q < vact);

  always_comb begin
    st_n   = st_q;
    skip_n = skip_q;
    got_n  = got_q;
    line_n = line_q;
    done_n = 1'b0;
    if (fe_edge) begin
      st_n   = V_RUN;
      skip_n = '0;
      got_n  = '0;
      line_n = 1'b0;
    end else if (st_q == V_RUN) begin
      if (line_q && !lv_level) begin
        line_n = 1'b0;
        if (got_q >= vact) begin
          done_n = 1'b1;
          st_n   = V_IDLE;
        end
      end else if (lv_rise) begin
        if (skip_q < voff) begin
          skip_n = skip_q + 1'b1;
        end else if (accept) begin
          line_n = 1'b1;
          got_n  = got_q + 1'b1;
        end
      end else if (!line_q && (vact == '0) && (skip_q >= voff)) begin
        done_n = 1'b1;
        st_n   = V_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= V_IDLE;
      skip_q <= '0;
      got_q  <= '0;
      line_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      skip_q <= skip_n;
      got_q  <= got_n;
      line_q <= line_n;
      done_q <= done_n;
    end
  end

  assign line_act   = line_q;
  assign frame_done = done_q;

  // R9: frame end is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4: a line opens only on a line-valid rise
  a_r4_line_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_q) |-> $past(lv_rise));

  // R10: an arming edge clears any open line and suppresses frame end
  a_r10_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fe_edge |=> (!line_q && !done_q));
endmodule

// File: rtl/acq_horz_ctl.sv
module acq_horz_ctl #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lv_rise,
  input  logic          lv_level,
  input  logic          accept,
  input  logic          line_act,
  input  logic [HW-1:0] hoff,
  input  logic [HW-1:0] hact,
  output logic          pix_wr
);
  localparam int LW = HW + 2;
  localparam logic [LW-1:0] GRAN_M1 = LW'(7);
  localparam logic [LW-1:0] IDX_MAX = {LW{1'b1}};

  logic [LW-1:0] pidx_q, pidx_n;
  logic [LW-1:0] cur, span, lim, hoff_x;
  logic          win, wr_n, wr_q;

  assign hoff_x = {2'b00, hoff};
  assign span   = ({2'b00, hact} + GRAN_M1) & ~GRAN_M1;
  assign lim    = hoff_x + span;
  assign cur    = lv_rise ? '0 : pidx_q;
  assign win    = lv_rise ? accept : line_act;

  always_comb begin
    pidx_n = pidx_q;
    if (lv_level && (cur != IDX_MAX)) begin
      pidx_n = cur + 1'b1;
    end
    wr_n = lv_level && win && (cur >= hoff_x) && (cur < lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pidx_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      pidx_q <= pidx_n;
      wr_q   <= wr_n;
    end
  end

  assign pix_wr = wr_q;

  // R8: a strobe always belongs to a pixel inside line-valid
  a_r8_wr_within_line: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(lv_level));
endmodule

// File: rtl/acq_window_gen.sv
module acq_window_gen
  import acq_win_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fen_i,
  input  logic              fen_pol_i,
  input  logic              lval_i,
  input  logic [VCFG_W-1:0] vwin_cfg_i,
  input  logic [HW-1:0]     hoff_i,
  input  logic [HW-1:0]     hact_i,
  input  logic [NTRIG-1:0]  trig_i,
  output logic              line_act_o,
  output logic              pix_wr_o,
  output logic              frame_done_o,
  output logic [STAT_W-1:0] status_o
);
  logic             fen_q, lv_q;
  logic             fe_edge, lv_rise;
  logic             accept, line_act;
  logic [NTRIG-1:0] trig_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q <= 1'b0;
      lv_q  <= 1'b0;
    end else begin
      fen_q <= fen_i;
      lv_q  <= lval_i;
    end
  end

  assign fe_edge = fen_pol_i ? (fen_i & ~fen_q) : (~fen_i & fen_q);
  assign lv_rise = lval_i & ~lv_q;

  acq_vert_ctl u_vert (
    .clk        (clk),
    .rst_n      (rst_n),
    .fe_edge    (fe_edge),
    .lv_rise    (lv_rise),
    .lv_level   (lval_i),
    .voff       (vwin_cfg_i[VOFF_W-1:0]),
    .vact       (vwin_cfg_i[VCFG_W-1:VOFF_W]),
    .accept     (accept),
    .line_act   (line_act),
    .frame_done (frame_done_o)
  );

  acq_horz_ctl #(.HW(HW)) u_horz (
    .clk      (clk),
    .rst_n    (rst_n),
    .lv_rise  (lv_rise),
    .lv_level (lval_i),
    .accept   (accept),
    .line_act (line_act),
    .hoff     (hoff_i),
    .hact     (hact_i),
    .pix_wr   (pix_wr_o)
  );

  acq_trig_sync #(.N(NTRIG)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (trig_i),
    .sync_o  (trig_s)
  );

  assign line_act_o = line_act;
  assign status_o   = {{PAD_W{1'b0}}, trig_s, vwin_cfg_i};

  // R5: an open line never outlives line-valid by more than one clock
  a_r5_line_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
    line_act_o |-> ($past(lval_i) || lval_i));
endmodule

// File: tb/test_acq_window_gen.sv
module test_acq_window_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fen_i = 1'b0;
  logic        fen_pol_i = 1'b1;
  logic        lval_i = 1'b0;
  logic [21:0] vwin_cfg_i = '0;
  logic [11:0] hoff_i = '0;
  logic [11:0] hact_i = '0;
  logic [6:0]  trig_i = '0;
  logic        line_act_o, pix_wr_o, frame_done_o;
  logic [31:0] status_o;

  int n_chk = 0;
  int n_bad = 0;
  int c_lines = 0, c_pix = 0, c_done = 0;
  logic prev_act = 1'b0, prev_done = 1'b0;
  bit finished = 0;

  always #10 clk = ~clk;

  acq_window_gen i_acq_window_gen (
    .clk(clk), .rst_n(rst_n), .fen_i(fen_i), .fen_pol_i(fen_pol_i),
    .lval_i(lval_i), .vwin_cfg_i(vwin_cfg_i), .hoff_i(hoff_i), .hact_i(hact_i),
    .trig_i(trig_i), .line_act_o(line_act_o), .pix_wr_o(pix_wr_o),
    .frame_done_o(frame_done_o), .status_o(status_o)
  );

  // columns: pol, voff, vact, hoff, hact, lines, len, exp_lines, exp_pix, exp_done
  localparam int NV = 9;
  localparam int VEC [NV][10] = '{
    '{1, 2, 3,  4,  8, 7, 20, 3, 24, 1},
    '{0, 0, 2,  0,  5, 4, 16, 2, 16, 1},
    '{1, 1, 4,  3,  9, 3, 40, 2, 32, 0},
    '{1, 0, 1, 10,  8, 2, 14, 1,  4, 1},
    '{0, 3, 0,  0,  8, 5, 10, 0,  0, 1},
    '{1, 0, 3,  0, 16, 3, 16, 3, 48, 1},
    '{1, 1, 1,  2,  1, 3, 12, 1,  8, 1},
    '{0, 5, 2,  0,  8, 4, 10, 0,  0, 0},
    '{1, 0, 1,  0,  0, 1, 10, 1,  0, 1}
  };

  always @(negedge clk) begin
    if (rst_n) begin
      if (line_act_o && !prev_act) c_lines++;
      if (pix_wr_o) c_pix++;
      if (frame_done_o) c_done++;
      if (frame_done_o && prev_done) begin
        n_bad++;
        $display("FAIL R9: frame_done held 2 cycles, actual 1 expected 0");
      end
    end
    prev_act  = line_act_o;
    prev_done = frame_done_o;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_lines(input int nl, input int len);
    for (int l = 0; l < nl; l++) begin
      lval_i = 1'b1;
      cyc(len);
      lval_i = 1'b0;
      cyc(4);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int b_l, b_p, b_d;
    cyc(3);
    check("R11 line_act in reset", int'(line_act_o), 0);
    check("R11 pix_wr in reset", int'(pix_wr_o), 0);
    check("R11 frame_done in reset", int'(frame_done_o), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 status after reset", int'(status_o), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      fen_pol_i  = VEC[v][0][0];
      vwin_cfg_i = {12'(VEC[v][2]), 10'(VEC[v][1])};
      hoff_i     = 12'(VEC[v][3]);
      hact_i     = 12'(VEC[v][4]);
      fen_i      = ~fen_pol_i;
      cyc(3);
      b_l = c_lines; b_p = c_pix; b_d = c_done;
      fen_i = fen_pol_i;
      cyc(2);
      send_lines(VEC[v][5], VEC[v][6]);
      cyc(6);
      check($sformatf("R5 vec%0d acquired lines", v), c_lines - b_l, VEC[v][7]);
      check($sformatf("R7 vec%0d write strobes", v), c_pix - b_p, VEC[v][8]);
      check($sformatf("R9 vec%0d frame_done count", v), c_done - b_d, VEC[v][9]);
    end

    // R3: opposite edge does not arm
    fen_pol_i  = 1'b1;
    vwin_cfg_i = {12'd2, 10'd0};
    hoff_i = 12'd0; hact_i = 12'd8;
    cyc(2);
    b_l = c_lines;
    fen_i = 1'b0;
    cyc(2);
    send_lines(2, 10);
    cyc(4);
    check("R3 falling edge ignored when rising selected", c_lines - b_l, 0);

    // R10: restart mid-frame, offset 1, two active lines
    vwin_cfg_i = {12'd2, 10'd1};
    cyc(2);
    b_l = c_lines; b_d = c_done;
    fen_i = 1'b1;
    cyc(2);
    send_lines(2, 10);
    check("R10 no done before restart", c_done - b_d, 0);
    fen_i = 1'b0;
    cyc(2);
    fen_i = 1'b1;
    cyc(2);
    send_lines(3, 10);
    cyc(4);
    check("R10 lines across restart", c_lines - b_l, 3);
    check("R10 one done after restart", c_done - b_d, 1);

    // R1/R2: status echo and synchronizer latency
    vwin_cfg_i = {12'hA5C, 10'h2B3};
    trig_i = 7'b1010011;
    cyc(4);
    check("R1 status word", int'(status_o), int'({3'b000, 7'b1010011, 12'hA5C, 10'h2B3}));
    trig_i = 7'b0101100;
    cyc(1);
    check("R1 trig after one edge", int'(status_o[28:22]), int'(7'b1010011));
    cyc(1);
    check("R1 trig after two edges", int'(status_o[28:22]), int'(7'b0101100));
    check("R1 pad bits zero", int'(status_o[31:29]), 0);

    // R11: reset mid-line
    vwin_cfg_i = {12'd2, 10'd0};
    fen_i = 1'b0;
    cyc(2);
    fen_i = 1'b1;
    cyc(2);
    lval_i = 1'b1;
    cyc(5);
    check("R4 line open before reset", int'(line_act_o), 1);
    rst_n = 1'b0;
    #1;
    check("R11 line_act cleared by reset", int'(line_act_o), 0);
    check("R11 trig cleared by reset", int'(status_o[28:22]), 0);
    lval_i = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(2);
    finish_run();
  end
endmodule